// File: doc/BRIEF.md
# Debug Event Capture with Instruction Breakpoints

This block sits beside an instruction pipeline. It watches every fetched program counter and every debug-related event strobe. Software programs two instruction-address breakpoint registers and a debug control word through a simple register port. The block compares each valid fetch address against both breakpoints, and it accepts strobes for a breakpoint instruction, a prefetch abort, a data breakpoint and a data abort.

If more than one event arrives in the same cycle, a fixed priority picks one winner. When the global debug enable is set, the winner is recorded. The entry code goes into a three-bit field of the control word. For the fault-type events, a status word and the faulting address are captured. For the events that stop the processor, a one-cycle trap request is raised.

When the enable is clear, nothing is recorded and no trap is raised. In that state a breakpoint instruction behaves as a no-op. Instruction decode and exception vectoring are done elsewhere.

Top module: `dbg_event_capture`

## Requirements
- R1: A breakpoint register with bit 0 set matches a valid fetch whose address bits 31:2 equal its bits 31:2; fetch address bits 1:0 are ignored. With a clear bit 0 it never matches. When debug is enabled, a match sets the entry field to 3'b001 and raises `trap_o` one cycle after the fetch.
- R2: The two breakpoint registers compare independently; a match on either one gives the R1 result.
- R3: Register map by index: 0 = breakpoint 0, 1 = breakpoint 1, 2 = control word (bit 31 global enable, bits 4:2 entry code, other bits read 0), 3 = fault status, 4 = fault address. Bit 1 of a breakpoint register reads 0. All registers and `trap_o` are 0 after reset.
- R4: A breakpoint instruction with debug enabled sets the entry code to 3'b011, fault status to 0x400, fault address to the fetch PC, and raises `trap_o`.
- R5: A breakpoint instruction with debug disabled is a no-op: no trap, and no register changes.
- R6: A prefetch abort with debug enabled sets fault status to 0x400 and fault address to the fetch PC. It leaves the entry code unchanged and raises no trap.
- R7: A data abort with debug enabled sets fault status to 0x001 and fault address to `daddr_i`. It raises no trap.
- R8: A data breakpoint with debug enabled sets the entry code to 3'b010 and raises `trap_o`. It leaves fault status and fault address unchanged.
- R9: Same-cycle events are resolved in the order instruction breakpoint, breakpoint instruction, prefetch abort, data breakpoint, data abort. Only the winner is recorded.
- R10: `trap_o` is high for exactly the one cycle after each trapping event.
- R11: A fetch address with `fetch_vld_i` low never causes a breakpoint match.
- R12: With the global enable clear, no event changes the entry code, fault status or fault address, and `trap_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | 1 | Fetch address is valid this cycle |
| fetch_pc_i | input | 32 | Fetch program counter; also the PC for the breakpoint instruction and prefetch abort |
| bkpt_i | input | 1 | Breakpoint instruction strobe |
| pabt_i | input | 1 | Prefetch abort strobe |
| dbrk_i | input | 1 | Data breakpoint strobe |
| dabt_i | input | 1 | Data abort strobe (multiple-register transfer) |
| daddr_i | input | 32 | Data access address for a data abort |
| cfg_we_i | input | 1 | Register write enable |
| cfg_waddr_i | input | 3 | Register write index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_raddr_i | input | 3 | Register read index |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| trap_o | output | 1 | One-cycle debug trap request |

## Verification
Some properties are checked by assertions on every cycle:
- the arbiter's grant vector is at most one-hot;
- a trap is never raised unless the enable was set in the cycle before;
- every trap comes with a non-zero entry code;
- the entry code holds while debug is disabled;
- a recorded breakpoint instruction or data abort leaves the expected fault status and address.

Other behaviours can only be shown by the bench's scenarios: the breakpoint masking of bits 1:0, the valid-bit qualification, the priority among combined strobes, and the fact that losing events leave no trace.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_IBRK = 3'd1,
    EV_BKPT = 3'd2,
    EV_PABT = 3'd3,
    EV_DBRK = 3'd4,
    EV_DABT = 3'd5
  } dbg_ev_e;

  localparam int unsigned NUM_EV = 5;

  localparam logic [2:0] MOE_IBRK = 3'b001;
  localparam logic [2:0] MOE_DBRK = 3'b010;
  localparam logic [2:0] MOE_BKPT = 3'b011;

  localparam logic [31:0] FSR_INSN = 32'h0000_0400;
  localparam logic [31:0] FSR_DATA = 32'h0000_0001;

endpackage

// File: rtl/dbg_ibp_cmp.sv
module dbg_ibp_cmp #(
  parameter int XLEN    = 32,
  parameter int NUM_IBP = 2
) (
  input  logic                           fetch_vld_i,
  input  logic [XLEN-1:0]                fetch_pc_i,
  input  logic [NUM_IBP-1:0][XLEN-1:0]   ibp_i,
  output logic [NUM_IBP-1:0]             hit_vec_o,
  output logic                           hit_o
);

  for (genvar g = 0; g < NUM_IBP; g++) begin : g_cmp
    logic addr_eq;
    assign addr_eq      = (ibp_i[g][XLEN-1:2] == fetch_pc_i[XLEN-1:2]);
    assign hit_vec_o[g] = fetch_vld_i & ibp_i[g][0] & addr_eq;
  end

  assign hit_o = |hit_vec_o;

endmodule

// File: rtl/dbg_evt_arb.sv
module dbg_evt_arb
  import dbg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_i,
  input  logic    ibrk_i,
  input  logic    bkpt_i,
  input  logic    pabt_i,
  input  logic    dbrk_i,
  input  logic    dabt_i,
  output dbg_ev_e ev_o,
  output logic    rec_o,
  output logic    trap_req_o
);

  logic [NUM_EV-1:0] req;
  logic [NUM_EV-1:0] grant;

  assign req = {dabt_i, dbrk_i, pabt_i, bkpt_i, ibrk_i};

  // fixed priority, lowest index wins
  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (req[i] && (grant == '0)) grant[i] = 1'b1;
    end
  end

  always_comb begin
    ev_o = EV_NONE;
    unique case (1'b1)
      grant[0]: ev_o = EV_IBRK;
      grant[1]: ev_o = EV_BKPT;
      grant[2]: ev_o = EV_PABT;
      grant[3]: ev_o = EV_DBRK;
      grant[4]: ev_o = EV_DABT;
      default:  ev_o = EV_NONE;
    endcase
  end

  assign rec_o      = en_i & (ev_o != EV_NONE);
  assign trap_req_o = en_i & ((ev_o == EV_IBRK) | (ev_o == EV_BKPT) | (ev_o == EV_DBRK));

  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_ibrk_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ibrk_i |-> (ev_o == EV_IBRK));

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IBP = 2,
  parameter int RA_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we_i,
  input  logic [RA_W-1:0]               cfg_waddr_i,
  input  logic [XLEN-1:0]               cfg_wdata_i,
  input  logic [RA_W-1:0]               cfg_raddr_i,
  output logic [XLEN-1:0]               cfg_rdata_o,
  input  logic                          rec_i,
  input  dbg_ev_e                       ev_i,
  input  logic [XLEN-1:0]               pc_i,
  input  logic [XLEN-1:0]               daddr_i,
  output logic [NUM_IBP-1:0][XLEN-1:0]  ibp_o,
  output logic                          en_o,
  output logic [2:0]                    moe_o
);

  localparam logic [RA_W-1:0] IDX_CTRL = RA_W'(NUM_IBP);
  localparam logic [RA_W-1:0] IDX_FSR  = RA_W'(NUM_IBP + 1);
  localparam logic [RA_W-1:0] IDX_FAR  = RA_W'(NUM_IBP + 2);

  logic [NUM_IBP-1:0][XLEN-1:0] ibp_q, ibp_d;
  logic                         en_q, en_d;
  logic [2:0]                   moe_q, moe_d;
  logic [XLEN-1:0]              fsr_q, fsr_d;
  logic [XLEN-1:0]              far_q, far_d;
  logic                         upd;

  // next-state
  always_comb begin
    ibp_d = ibp_q;
    en_d  = en_q;
    moe_d = moe_q;
    fsr_d = fsr_q;
    far_d = far_q;
    if (cfg_we_i) begin
      for (int i = 0; i < NUM_IBP; i++) begin
        if (cfg_waddr_i == RA_W'(i))
          ibp_d[i] = {cfg_wdata_i[XLEN-1:2], 1'b0, cfg_wdata_i[0]};
      end
      if (cfg_waddr_i == IDX_CTRL) begin
        en_d  = cfg_wdata_i[XLEN-1];
        moe_d = cfg_wdata_i[4:2];
      end
      if (cfg_waddr_i == IDX_FSR) fsr_d = cfg_wdata_i;
      if (cfg_waddr_i == IDX_FAR) far_d = cfg_wdata_i;
    end
    // recorded events override a same-cycle write of the same field
    if (rec_i) begin
      unique case (ev_i)
        EV_IBRK: moe_d = MOE_IBRK;
        EV_BKPT: begin
          moe_d = MOE_BKPT;
          fsr_d = XLEN'(FSR_INSN);
          far_d = pc_i;
        end
        EV_PABT: begin
          fsr_d = XLEN'(FSR_INSN);
          far_d = pc_i;
        end
        EV_DBRK: moe_d = MOE_DBRK;
        EV_DABT: begin
          fsr_d = XLEN'(FSR_DATA);
          far_d = daddr_i;
        end
        default: ;
      endcase
    end
  end

  assign upd = cfg_we_i | rec_i;

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibp_q <= '0;
      en_q  <= 1'b0;
      moe_q <= '0;
      fsr_q <= '0;
      far_q <= '0;
    end else if (upd) begin
      ibp_q <= ibp_d;
      en_q  <= en_d;
      moe_q <= moe_d;
      fsr_q <= fsr_d;
      far_q <= far_d;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_IBP; i++) begin
      if (cfg_raddr_i == RA_W'(i)) cfg_rdata_o = ibp_q[i];
    end
    if (cfg_raddr_i == IDX_CTRL) begin
      cfg_rdata_o[XLEN-1] = en_q;
      cfg_rdata_o[4:2]    = moe_q;
    end
    if (cfg_raddr_i == IDX_FSR) cfg_rdata_o = fsr_q;
    if (cfg_raddr_i == IDX_FAR) cfg_rdata_o = far_q;
  end

  assign ibp_o = ibp_q;
  assign en_o  = en_q;
  assign moe_o = moe_q;

  p_moe_hold_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(cfg_we_i && cfg_waddr_i == IDX_CTRL)) |=> $stable(moe_q));

  p_fsr_bkpt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && ev_i == EV_BKPT) |=> (fsr_q == XLEN'(FSR_INSN) && far_q == $past(pc_i)));

  p_far_dabt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && ev_i == EV_DABT) |=> (fsr_q == XLEN'(FSR_DATA) && far_q == $past(daddr_i)));

endmodule

// File: rtl/dbg_event_capture.sv
module dbg_event_capture
  import dbg_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IBP = 2,
  parameter int RA_W    = $clog2(NUM_IBP + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_vld_i,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic            bkpt_i,
  input  logic            pabt_i,
  input  logic            dbrk_i,
  input  logic            dabt_i,
  input  logic [XLEN-1:0] daddr_i,
  input  logic            cfg_we_i,
  input  logic [RA_W-1:0] cfg_waddr_i,
  input  logic [XLEN-1:0] cfg_wdata_i,
  input  logic [RA_W-1:0] cfg_raddr_i,
  output logic [XLEN-1:0] cfg_rdata_o,
  output logic            trap_o
);

  logic [NUM_IBP-1:0][XLEN-1:0] ibp;
  logic [NUM_IBP-1:0]           hit_vec;
  logic                         ib_hit;
  logic                         en;
  logic [2:0]                   moe;
  dbg_ev_e                      ev;
  logic                         rec;
  logic                         trap_req;
  logic                         trap_q, trap_d;

  dbg_ibp_cmp #(.XLEN(XLEN), .NUM_IBP(NUM_IBP)) u_cmp (
    .fetch_vld_i (fetch_vld_i),
    .fetch_pc_i  (fetch_pc_i),
    .ibp_i       (ibp),
    .hit_vec_o   (hit_vec),
    .hit_o       (ib_hit)
  );

  dbg_evt_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .ibrk_i     (ib_hit),
    .bkpt_i     (bkpt_i),
    .pabt_i     (pabt_i),
    .dbrk_i     (dbrk_i),
    .dabt_i     (dabt_i),
    .ev_o       (ev),
    .rec_o      (rec),
    .trap_req_o (trap_req)
  );

  dbg_regfile #(.XLEN(XLEN), .NUM_IBP(NUM_IBP), .RA_W(RA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we_i),
    .cfg_waddr_i (cfg_waddr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_raddr_i (cfg_raddr_i),
    .cfg_rdata_o (cfg_rdata_o),
    .rec_i       (rec),
    .ev_i        (ev),
    .pc_i        (fetch_pc_i),
    .daddr_i     (daddr_i),
    .ibp_o       (ibp),
    .en_o        (en),
    .moe_o       (moe)
  );

  assign trap_d = trap_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign trap_o = trap_q;

  p_trap_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(en));

  p_trap_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (moe != 3'b000));

  p_hit_needs_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld_i |-> (hit_vec == '0));

endmodule

// File: tb/test_dbg_event_capture.sv
`timescale 1ns/100ps
module test_dbg_event_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        bkpt_i = 1'b0, pabt_i = 1'b0, dbrk_i = 1'b0, dabt_i = 1'b0;
  logic [31:0] daddr_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_waddr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [2:0]  cfg_raddr_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        trap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_event_capture i_dbg_event_capture (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld_i(fetch_vld_i), .fetch_pc_i(fetch_pc_i),
    .bkpt_i(bkpt_i), .pabt_i(pabt_i), .dbrk_i(dbrk_i), .dabt_i(dabt_i),
    .daddr_i(daddr_i),
    .cfg_we_i(cfg_we_i), .cfg_waddr_i(cfg_waddr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_raddr_i(cfg_raddr_i), .cfg_rdata_o(cfg_rdata_o), .trap_o(trap_o)
  );

  typedef struct {
    string       tag;
    logic        trap;
    logic [31:0] ctrl;
    logic [31:0] fsr;
    logic [31:0] far;
  } exp_t;

  exp_t sb[$];

  // reference state, from the requirements
  logic [31:0] m_ibp0 = '0, m_ibp1 = '0, m_fsr = '0, m_far = '0;
  logic        m_en = 1'b0;
  logic [2:0]  m_moe = '0;

  function automatic logic [31:0] m_ctrl();
    return {m_en, 26'b0, m_moe, 2'b00};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %08h exp %08h", tag, what, got, exp);
    end
  endtask

  task automatic push(string tag, logic trap);
    exp_t e;
    e.tag = tag; e.trap = trap; e.ctrl = m_ctrl(); e.fsr = m_fsr; e.far = m_far;
    sb.push_back(e);
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    fetch_vld_i = 0; bkpt_i = 0; pabt_i = 0; dbrk_i = 0; dabt_i = 0;
    cfg_we_i = 1; cfg_waddr_i = a; cfg_wdata_i = d;
    @(posedge clk); #1;
    cfg_we_i = 0;
    case (a)
      3'd0: m_ibp0 = {d[31:2], 1'b0, d[0]};
      3'd1: m_ibp1 = {d[31:2], 1'b0, d[0]};
      3'd2: begin m_en = d[31]; m_moe = d[4:2]; end
      3'd3: m_fsr = d;
      3'd4: m_far = d;
      default: ;
    endcase
    push(tag, 1'b0);
  endtask

  task automatic step(string tag, logic fv, logic [31:0] pc, logic bk, logic pa,
                      logic db, logic da, logic [31:0] dad);
    logic hit, trap;
    @(negedge clk);
    fetch_vld_i = fv; fetch_pc_i = pc; bkpt_i = bk; pabt_i = pa;
    dbrk_i = db; dabt_i = da; daddr_i = dad; cfg_we_i = 0;
    @(posedge clk); #1;
    hit = fv && ((m_ibp0[0] && m_ibp0[31:2] == pc[31:2]) ||
                 (m_ibp1[0] && m_ibp1[31:2] == pc[31:2]));
    trap = 1'b0;
    if (m_en) begin
      if (hit)     begin m_moe = 3'b001; trap = 1; end
      else if (bk) begin m_moe = 3'b011; m_fsr = 32'h400; m_far = pc; trap = 1; end
      else if (pa) begin m_fsr = 32'h400; m_far = pc; end
      else if (db) begin m_moe = 3'b010; trap = 1; end
      else if (da) begin m_fsr = 32'h001; m_far = dad; end
    end
    push(tag, trap);
  endtask

  // monitor: one expected item per cycle, checked at the following negedge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "trap", {31'b0, trap_o}, {31'b0, e.trap});
        cfg_raddr_i = 3'd2; #0.5;
        chk(e.tag, "ctrl", cfg_rdata_o, e.ctrl);
        cfg_raddr_i = 3'd3; #0.5;
        chk(e.tag, "fsr", cfg_rdata_o, e.fsr);
        cfg_raddr_i = 3'd4; #0.5;
        chk(e.tag, "far", cfg_rdata_o, e.far);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3 reset state, read through the register port
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      cfg_raddr_i = 3'(i); #0.5;
      chk("R3", "reset reg", cfg_rdata_o, 32'h0);
    end
    chk("R3", "reset trap", {31'b0, trap_o}, 32'h0);

    wr("R3", 3'd0, 32'h0000_1003);         // bit 1 dropped
    @(negedge clk); #2;
    cfg_raddr_i = 3'd0; #0.5;
    chk("R3", "ibp0 readback", cfg_rdata_o, 32'h0000_1001);
    wr("R3", 3'd1, 32'h0000_2001);

    // disabled: nothing recorded
    step("R12", 1, 32'h0000_1000, 0, 0, 0, 0, 0);
    step("R5",  1, 32'h0000_3000, 1, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 1, 1, 1, 32'h55);

    wr("R3", 3'd2, 32'h8000_0000);
    step("R1",  1, 32'h0000_1002, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    step("R2",  1, 32'h0000_2003, 0, 0, 0, 0, 0);
    step("R11", 0, 32'h0000_1000, 0, 0, 0, 0, 0);
    step("R4",  1, 32'h0000_3000, 1, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    step("R6",  1, 32'h0000_4000, 0, 1, 0, 0, 0);
    step("R7",  0, 0, 0, 0, 0, 1, 32'h0000_5004);
    step("R8",  0, 0, 0, 0, 1, 0, 0);
    step("R9",  1, 32'h0000_1000, 1, 1, 1, 1, 32'h77);
    step("R9",  1, 32'h0000_6000, 1, 0, 0, 1, 32'h88);
    step("R9",  1, 32'h0000_7000, 0, 1, 1, 1, 32'h99);
    step("R9",  0, 0, 0, 0, 1, 1, 32'hAA);
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    // invalid breakpoint never matches
    wr("R1", 3'd0, 32'h0000_1000);
    step("R1",  1, 32'h0000_1000, 0, 0, 0, 0, 0);
    // disable again
    wr("R12", 3'd2, 32'h0000_0000);
    step("R12", 1, 32'h0000_2000, 0, 0, 0, 1, 32'hBB);
    step("R5",  1, 32'h0000_8000, 1, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0);

    while (sb.size() > 0) @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule